// File: doc/BRIEF.md
# Timer Bus Front End and Control Decoder

This block sits between an 8-bit processor bus and a group of three counter channels. It samples the bus strobes on the system clock and qualifies them with an active-low chip select. It uses two address bits to pick one of four targets: one of the three channels, or a control register that can only be written. A write to a channel address becomes a one-cycle byte-write pulse for that channel. A read from a channel address drives that channel's byte onto the bus and gives the channel a one-cycle read pulse.

A byte written to the control address is decoded, not stored. Its top two bits name a channel. Its access-format field decides the action. A non-zero format sends a one-cycle program pulse to that channel, together with the decoded mode, the BCD bit and the format. A zero format sends a one-cycle latch pulse and leaves the stored mode and format unchanged. A channel selector of 11 is the read-back command. The block only reports it, with a one-cycle flag, and does not carry it out. The counting logic belongs to the channels and is not part of this block.

Every access is registered. A strobe that the clock samples low at one rising edge produces its pulse after the next rising edge. A strobe held low acts once.

Top module: `tmr_bus_front`

## Requirements
- R1: While reset is active, and after it is released, every pulse output (wr_stb, rd_en, prog_stb, latch_stb, rb_stb) is low, dout_oe is low and prog_mode is 0.
- R2: While cs_n is high, rd_n and wr_n have no effect: no pulse output rises and dout_oe stays low.
- R3: A qualified write to address 0, 1 or 2 raises wr_stb[addr] for exactly one cycle, with wr_data equal to the written byte. The pulse is visible after the second rising edge that follows the strobe going low.
- R4: A qualified strobe held low for several cycles produces only one pulse. A new access needs the strobe to go high and then low again.
- R5: A control byte written to address 3 is split into four fields: bits 7:6 select the channel, bits 5:4 give the format, bits 3:1 give the mode code, and bit 0 gives BCD. When the selector is 0 to 2 and the format is non-zero, prog_stb[selector] pulses for one cycle with prog_fmt equal to the format and prog_bcd equal to bit 0.
- R6: The mode code is decoded into prog_mode as follows: 110 gives 2, 111 gives 3, and every other code keeps its own value (0, 1, 2, 3, 4 or 5).
- R7: A control byte with format 00 and a selector from 0 to 2 raises latch_stb[selector] for one cycle. No prog_stb pulse occurs, and prog_mode keeps its previous value.
- R8: A control byte with selector 11 raises rb_stb for one cycle. It causes no prog_stb, latch_stb or wr_stb pulse and leaves prog_mode unchanged.
- R9: A qualified read at address 0, 1 or 2 drives dout_oe high, with dout equal to byte [8*addr+7:8*addr] of ch_rdata, from the first rising edge after the strobe goes low. The same read raises rd_en[addr] for one cycle one edge later.
- R10: A read at address 3 leaves dout_oe low (the bus stays undriven) and raises no rd_en bit.
- R11: Read and write strobes are handled independently. If both fall in the same sampled cycle at a channel address, wr_stb and rd_en for that channel pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Target select: 0 to 2 for channels, 3 for the control register |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus, 0 when not driving |
| dout_oe | output | 1 | Bus drive enable; low means the bus is left at high impedance |
| ch_rdata | input | 24 | Read bytes from the three channels, channel n at bits 8n+7:8n |
| wr_stb | output | 3 | One-cycle byte-write pulse, one bit per channel |
| wr_data | output | 8 | Byte that goes with wr_stb |
| rd_en | output | 3 | One-cycle byte-read pulse, one bit per channel |
| prog_stb | output | 3 | One-cycle program pulse, one bit per channel |
| prog_mode | output | 3 | Decoded mode that goes with prog_stb |
| prog_bcd | output | 1 | BCD bit that goes with prog_stb |
| prog_fmt | output | 2 | Access format that goes with prog_stb |
| latch_stb | output | 3 | One-cycle latch-command pulse, one bit per channel |
| rb_stb | output | 1 | One-cycle flag for a read-back command |

## Verification
The read path and the write path share the sampled address but have separate edge detectors. A read pulse and a write pulse can therefore fall in the same cycle. The bench provokes this by pulling rd_n and wr_n low on the same clock at a channel address. It then checks that wr_stb and rd_en for that channel rise together after the second edge and that both clear one cycle later. A second overlap case is a latch command or a read-back command arriving while prog_mode holds a value from an earlier program byte. The bench judges it by reading prog_mode back at the ports and confirming it is unchanged.

// File: rtl/tmr_bus_front.sv
module tmr_bus_front (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [1:0]  addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_oe,
  input  logic [23:0] ch_rdata,
  output logic [2:0]  wr_stb,
  output logic [7:0]  wr_data,
  output logic [2:0]  rd_en,
  output logic [2:0]  prog_stb,
  output logic [2:0]  prog_mode,
  output logic        prog_bcd,
  output logic [1:0]  prog_fmt,
  output logic [2:0]  latch_stb,
  output logic        rb_stb
);
  localparam logic [1:0] CTRL = 2'b11;

  logic       cs_q, rd_q, wr_q, wq_d, rq_d;
  logic [1:0] a_q;
  logic [7:0] d_q;

  wire wq     = !cs_q && !wr_q;
  wire rq     = !cs_q && !rd_q;
  wire w_fall = wq && !wq_d;
  wire r_fall = rq && !rq_d;

  wire [1:0] sel  = d_q[7:6];
  wire [1:0] fmt  = d_q[5:4];
  wire [2:0] mcod = d_q[3:1];
  wire [2:0] mdec = mcod[1] ? {1'b0, mcod[1:0]} : mcod;

  assign dout_oe = rq && (a_q != CTRL);
  assign dout    = dout_oe ? ch_rdata[{a_q, 3'b000} +: 8] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1; rd_q <= 1'b1; wr_q <= 1'b1;
      wq_d <= 1'b0; rq_d <= 1'b0;
      a_q  <= '0;   d_q  <= '0;
    end else begin
      cs_q <= cs_n; rd_q <= rd_n; wr_q <= wr_n;
      wq_d <= wq;   rq_d <= rq;
      a_q  <= addr; d_q  <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb <= '0; wr_data <= '0; rd_en <= '0;
      prog_stb <= '0; prog_mode <= '0; prog_bcd <= 1'b0; prog_fmt <= '0;
      latch_stb <= '0; rb_stb <= 1'b0;
    end else begin
      wr_stb <= '0; rd_en <= '0; prog_stb <= '0; latch_stb <= '0; rb_stb <= 1'b0;
      if (w_fall) begin
        if (a_q != CTRL) begin
          wr_stb[a_q] <= 1'b1;
          wr_data     <= d_q;
        end else if (sel == CTRL) begin
          rb_stb <= 1'b1;
        end else if (fmt == 2'b00) begin
          latch_stb[sel] <= 1'b1;
        end else begin
          prog_stb[sel] <= 1'b1;
          prog_mode     <= mdec;
          prog_bcd      <= d_q[0];
          prog_fmt      <= fmt;
        end
      end
      if (r_fall && (a_q != CTRL)) rd_en[a_q] <= 1'b1;
    end
  end

  p_ignore_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> (wr_stb == 3'b0 && rd_en == 3'b0 && prog_stb == 3'b0 && latch_stb == 3'b0 && !rb_stb));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, prog_stb, latch_stb, rb_stb}));

  p_single_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |=> !(|wr_stb));

  p_single_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_en) |=> !(|rd_en));

  p_fmt_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|prog_stb) |-> (prog_fmt != 2'b00));

  p_mode_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|prog_stb) |-> (prog_mode <= 3'd5));

  p_latch_keeps_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|latch_stb) |-> $stable(prog_mode));

  p_rb_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_stb |-> (prog_stb == 3'b0 && latch_stb == 3'b0 && wr_stb == 3'b0 && $stable(prog_mode)));
endmodule

// File: tb/tmr_bus_front_bench.sv
module tmr_bus_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  din = '0;
  logic [23:0] ch_rdata = 24'hC3B2A1;
  logic [7:0]  dout;
  logic        dout_oe;
  logic [2:0]  wr_stb, rd_en, prog_stb, latch_stb, prog_mode;
  logic [7:0]  wr_data;
  logic        prog_bcd, rb_stb;
  logic [1:0]  prog_fmt;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tmr_bus_front u_tmr_bus_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .ch_rdata(ch_rdata),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_en(rd_en), .prog_stb(prog_stb),
    .prog_mode(prog_mode), .prog_bcd(prog_bcd), .prog_fmt(prog_fmt),
    .latch_stb(latch_stb), .rb_stb(rb_stb));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    check(req, {wr_stb, rd_en, prog_stb, latch_stb, rb_stb, dout_oe}, 0);
  endtask

  task automatic start(input logic c, input logic r, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = c; rd_n = r; wr_n = w; addr = a; din = d;
  endtask

  task automatic to_pulse;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic idle;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    quiet("R1 reset pulses");
    check("R1 reset mode", prog_mode, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    quiet("R1 after reset");
  endtask

  task automatic t_counter_write;
    for (int a = 0; a < 3; a++) begin
      start(1'b0, 1'b1, 1'b0, a[1:0], 8'h40 + 8'(a));
      to_pulse;
      check("R3 wr_stb", wr_stb, 1 << a);
      check("R3 wr_data", wr_data, 8'h40 + a);
      check("R3 no prog", prog_stb, 0);
      @(negedge clk);
      check("R4 held low once", wr_stb, 0);
      @(negedge clk);
      check("R4 still once", wr_stb, 0);
      idle;
    end
  endtask

  task automatic t_cs_high;
    start(1'b1, 1'b0, 1'b0, 2'd1, 8'h55);
    @(negedge clk);
    check("R2 no drive", dout_oe, 0);
    @(negedge clk);
    quiet("R2 no pulses");
    @(negedge clk);
    quiet("R2 no pulses later");
    idle;
    start(1'b1, 1'b1, 1'b0, 2'd3, 8'h77);
    to_pulse;
    quiet("R2 ctrl ignored");
    check("R2 mode untouched", prog_mode, 0);
    idle;
  endtask

  task automatic t_program;
    start(1'b0, 1'b1, 1'b0, 2'd3, 8'h77);
    to_pulse;
    check("R5 prog_stb", prog_stb, 3'b010);
    check("R5 fmt", prog_fmt, 3);
    check("R5 bcd", prog_bcd, 1);
    check("R6 mode 3", prog_mode, 3);
    check("R5 no latch", latch_stb, 0);
    @(negedge clk);
    check("R5 one cycle", prog_stb, 0);
    idle;
  endtask

  task automatic t_mode_decode;
    logic [2:0] codes [5] = '{3'b110, 3'b111, 3'b100, 3'b101, 3'b001};
    int exps [5] = '{2, 3, 4, 5, 1};
    for (int i = 0; i < 5; i++) begin
      start(1'b0, 1'b1, 1'b0, 2'd3, {2'b10, 2'b01, codes[i], 1'b0});
      to_pulse;
      check("R6 prog_stb ch2", prog_stb, 3'b100);
      check("R6 mode", prog_mode, exps[i]);
      check("R5 fmt low only", prog_fmt, 1);
      check("R5 bcd clear", prog_bcd, 0);
      idle;
    end
  endtask

  task automatic t_latch;
    start(1'b0, 1'b1, 1'b0, 2'd3, 8'h0E);
    to_pulse;
    check("R7 latch ch0", latch_stb, 3'b001);
    check("R7 no prog", prog_stb, 0);
    check("R7 mode kept", prog_mode, 1);
    check("R7 fmt kept", prog_fmt, 1);
    @(negedge clk);
    check("R7 one cycle", latch_stb, 0);
    idle;
  endtask

  task automatic t_readback;
    start(1'b0, 1'b1, 1'b0, 2'd3, 8'hF6);
    to_pulse;
    check("R8 rb flag", rb_stb, 1);
    check("R8 no channel", {prog_stb, latch_stb, wr_stb}, 0);
    check("R8 mode kept", prog_mode, 1);
    @(negedge clk);
    check("R8 one cycle", rb_stb, 0);
    idle;
  endtask

  task automatic t_read;
    start(1'b0, 1'b0, 1'b1, 2'd2, 8'h00);
    @(negedge clk);
    check("R9 oe", dout_oe, 1);
    check("R9 data ch2", dout, 8'hC3);
    check("R9 rd_en not yet", rd_en, 0);
    @(negedge clk);
    check("R9 rd_en ch2", rd_en, 3'b100);
    @(negedge clk);
    check("R9 rd_en once", rd_en, 0);
    check("R9 still driving", dout, 8'hC3);
    idle;
    check("R9 released", dout_oe, 0);
    start(1'b0, 1'b0, 1'b1, 2'd0, 8'h00);
    @(negedge clk);
    check("R9 data ch0", dout, 8'hA1);
    idle;
  endtask

  task automatic t_read_ctrl;
    start(1'b0, 1'b0, 1'b1, 2'd3, 8'h00);
    @(negedge clk);
    check("R10 no drive", dout_oe, 0);
    @(negedge clk);
    check("R10 no rd_en", rd_en, 0);
    idle;
  endtask

  task automatic t_both;
    start(1'b0, 1'b0, 1'b0, 2'd1, 8'h9C);
    to_pulse;
    check("R11 wr_stb", wr_stb, 3'b010);
    check("R11 rd_en", rd_en, 3'b010);
    check("R11 wr_data", wr_data, 8'h9C);
    check("R11 dout ch1", dout, 8'hB2);
    @(negedge clk);
    check("R11 both clear", {wr_stb, rd_en}, 0);
    idle;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_counter_write;
    t_cs_high;
    t_program;
    t_mode_decode;
    t_latch;
    t_readback;
    t_read;
    t_read_ctrl;
    t_both;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule